// File: doc/BRIEF.md
# Variable-Width Symbol Unpacker

The unpacker takes a stream of wide data elements over a valid/ready handshake and cuts each one into symbols of 8, 12 or 16 bits, one symbol per cycle on a second valid/ready interface. The symbol width comes from a 3-bit size code. Symbols are taken starting at the least significant bit of each element. A 12-bit width does not divide a 128-bit element, so the bits left after the last whole symbol of an element are held in a residue register. They become the low-order bits of the first symbol built from the next element.

An element flagged as the end of the stream closes the stream. If a residue remains after its last whole symbol, that residue goes out as one more symbol, zero-padded in its upper bits. The final symbol of the stream carries a last flag. After the final symbol the residue is cleared, so the next stream starts with nothing carried over.

A control machine has three states:
- `ST_IDLE` waits for an element with input ready raised.
- `ST_EMIT` presents whole symbols from the held element.
- `ST_FLUSH` presents the padded residue at end of stream.

Its transitions are:
- IDLE→EMIT on an accepted element.
- EMIT→EMIT while at least one more whole symbol remains.
- EMIT→IDLE when the element is used up, or when only a partial residue remains and the element was not the last.
- EMIT→FLUSH when a partial residue remains after a last element.
- FLUSH→IDLE when the padded symbol is accepted.

Top module: `symbol_unpacker`

## Requirements
- R1: After reset, with a valid size code, `in_ready` is 1, `out_valid` is 0 and `cfg_err` is 0.
- R2: Size code 0 gives 8-bit symbols, code 1 gives 12-bit symbols and code 2 gives 16-bit symbols. Bits of `out_sym` above the symbol width are 0.
- R3: Symbol k of an element with no residue carried in is made of element bits [k*W+W-1 : k*W], for symbol width W.
- R4: Leftover bits of an element form the low-order bits of the next symbol, and the next element supplies its upper bits. With 12-bit symbols, consecutive elements yield 10, 11 and 11 symbols, leaving residues of 8, 4 and 0 bits.
- R5: Size codes 3 to 7 drive `cfg_err` to 1, hold `in_ready` and `out_valid` at 0, and accept nothing. Normal operation resumes once a valid code is applied.
- R6: When the last element has been split, a non-empty residue is emitted as one extra symbol, zero-padded above the residue, with `out_last` at 1. If no residue remains, the last whole symbol carries `out_last`. No other symbol has `out_last` at 1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_sym` and `out_last` stay unchanged. No symbol is lost or duplicated.
- R8: `in_ready` is 0 whenever a symbol is being presented (`out_valid` is 1), so the input stalls while buffered bits still hold output.
- R9: After the last symbol of a stream is accepted, `out_valid` drops and the residue is cleared. The next stream's first symbol holds only bits of its own first element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 3 | Symbol size code (0: 8, 1: 12, 2: 16, others reserved) |
| cfg_err | output | 1 | Reserved size code applied |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Unpacker can take an element |
| in_data | input | ELEM_W | Input element, symbols taken LSB first |
| in_last | input | 1 | Element ends the stream |
| out_valid | output | 1 | Symbol valid |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 16 | Symbol, zero-extended above its width |
| out_last | output | 1 | Final symbol of the stream |

## Verification
The bench builds the unpacker with its default 128-bit element, so 12-bit symbols go through the full three-element residue cycle of 8, 4 and 0 bits. Both 8-bit and 16-bit symbols divide that element exactly. Streams of one to eight elements therefore reach the padded final symbol with a 4-bit or an 8-bit residue, as well as the exact-fit end, with each size code. Random `out_ready` and `in_valid` patterns hold the interface in backpressure across element boundaries.

// File: rtl/symunp_pkg.sv
package symunp_pkg;
    localparam int SYM_MAX = 16;
    localparam int WID_W   = $clog2(SYM_MAX + 1);
    localparam int RES_W   = $clog2(SYM_MAX);

    typedef enum logic [2:0] {
        SZ_B8  = 3'd0,
        SZ_B12 = 3'd1,
        SZ_B16 = 3'd2
    } size_code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT  = 2'd1,
        ST_FLUSH = 2'd2
    } unp_state_e;
endpackage

// File: rtl/sym_width_decode.sv
module sym_width_decode
    import symunp_pkg::*;
(
    input  logic [2:0]       code,
    output logic [WID_W-1:0] width,
    output logic             err
);
    always_comb begin
        err = 1'b0;
        unique case (code)
            SZ_B8:   width = WID_W'(8);
            SZ_B12:  width = WID_W'(12);
            SZ_B16:  width = WID_W'(16);
            default: begin
                width = WID_W'(SYM_MAX);
                err   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sym_compose.sv
module sym_compose
    import symunp_pkg::*;
#(
    parameter int ELEM_W = 128,
    parameter int POS_W  = $clog2(ELEM_W + 1)
) (
    input  logic [ELEM_W-1:0]  elem,
    input  logic [POS_W-1:0]   pos,
    input  logic [SYM_MAX-1:0] res,
    input  logic [RES_W-1:0]   res_cnt,
    input  logic [WID_W-1:0]   width,
    output logic [SYM_MAX-1:0] sym
);
    logic [SYM_MAX-1:0] win;
    logic [SYM_MAX-1:0] joined;
    logic [SYM_MAX-1:0] mask;

    always_comb begin
        win    = SYM_MAX'(elem >> pos);
        joined = (win << res_cnt) | res;
        mask   = SYM_MAX'((32'd1 << width) - 32'd1);
        sym    = joined & mask;
    end
endmodule

// File: rtl/symbol_unpacker.sv
module symbol_unpacker
    import symunp_pkg::*;
#(
    parameter int ELEM_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_size,
    output logic               cfg_err,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ELEM_W-1:0]  in_data,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [SYM_MAX-1:0] out_sym,
    output logic               out_last
);
    localparam int POS_W = $clog2(ELEM_W + 1);

    unp_state_e         state_q, state_d;
    logic [ELEM_W-1:0]  elem_q, elem_d;
    logic [POS_W-1:0]   pos_q, pos_d;
    logic [SYM_MAX-1:0] res_q, res_d;
    logic [RES_W-1:0]   res_cnt_q, res_cnt_d;
    logic               last_q, last_d;

    logic [WID_W-1:0]   sym_w;
    logic               size_bad;
    logic [POS_W-1:0]   take, pos_adv, left_adv;
    logic [SYM_MAX-1:0] cur_sym, tail_bits;
    logic               in_fire, out_fire;

    sym_width_decode u_dec (
        .code  (cfg_size),
        .width (sym_w),
        .err   (size_bad)
    );

    sym_compose #(.ELEM_W(ELEM_W), .POS_W(POS_W)) u_cur (
        .elem    (elem_q),
        .pos     (pos_q),
        .res     (res_q),
        .res_cnt (res_cnt_q),
        .width   (sym_w),
        .sym     (cur_sym)
    );

    sym_compose #(.ELEM_W(ELEM_W), .POS_W(POS_W)) u_tail (
        .elem    (elem_q),
        .pos     (pos_adv),
        .res     ('0),
        .res_cnt ('0),
        .width   (WID_W'(SYM_MAX)),
        .sym     (tail_bits)
    );

    always_comb begin
        take     = POS_W'(sym_w) - POS_W'(res_cnt_q);
        pos_adv  = pos_q + take;
        left_adv = POS_W'(ELEM_W) - pos_adv;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            pos_q     <= '0;
            res_q     <= '0;
            res_cnt_q <= '0;
            last_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            elem_q    <= elem_d;
            pos_q     <= pos_d;
            res_q     <= res_d;
            res_cnt_q <= res_cnt_d;
            last_q    <= last_d;
        end
    end

    // outputs
    always_comb begin
        cfg_err   = size_bad;
        in_ready  = (state_q == ST_IDLE) && !size_bad;
        out_valid = (state_q != ST_IDLE) && !size_bad;
        out_sym   = (state_q == ST_FLUSH) ? res_q : cur_sym;
        out_last  = (state_q == ST_FLUSH) ||
                    ((state_q == ST_EMIT) && last_q && (left_adv == '0));
        in_fire   = in_valid && in_ready;
        out_fire  = out_valid && out_ready;
    end

    // next state
    always_comb begin
        state_d   = state_q;
        elem_d    = elem_q;
        pos_d     = pos_q;
        res_d     = res_q;
        res_cnt_d = res_cnt_q;
        last_d    = last_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_fire) begin
                    elem_d  = in_data;
                    pos_d   = '0;
                    last_d  = in_last;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_fire) begin
                    pos_d     = pos_adv;
                    res_d     = '0;
                    res_cnt_d = '0;
                    if (left_adv >= POS_W'(sym_w)) begin
                        state_d = ST_EMIT;
                    end else if (left_adv == '0) begin
                        state_d = ST_IDLE;
                    end else begin
                        res_d     = tail_bits;
                        res_cnt_d = RES_W'(left_adv);
                        state_d   = last_q ? ST_FLUSH : ST_IDLE;
                    end
                end
            end
            ST_FLUSH: begin
                if (out_fire) begin
                    res_d     = '0;
                    res_cnt_d = '0;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/symunp_checker.sv
module symunp_checker
    import symunp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cfg_size,
    input logic               cfg_err,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [SYM_MAX-1:0] out_sym,
    input logic               out_last
);
    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size > 3'd2) |-> (cfg_err && !in_ready && !out_valid)); // R5

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_last))); // R7

    AST_INPUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8

    AST_PAD_B8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_size == 3'd0) |-> (out_sym[15:8] == 8'h00)); // R2

    AST_PAD_B12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_size == 3'd1) |-> (out_sym[15:12] == 4'h0)); // R2

    AST_DRAIN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid); // R9
endmodule

bind symbol_unpacker symunp_checker u_symunp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_size  (cfg_size),
    .cfg_err   (cfg_err),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym),
    .out_last  (out_last)
);

// File: tb/symbol_unpacker_bench.sv
module symbol_unpacker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_size = 3'd0;
    logic          cfg_err;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [EW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [15:0]   out_sym;
    logic          out_last;

    int errs = 0;
    int checks = 0;
    logic [EW-1:0] elems [0:15];
    logic [15:0]   got   [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    symbol_unpacker #(.ELEM_W(EW)) u_symbol_unpacker (
        .clk, .rst_n, .cfg_size, .cfg_err, .in_valid, .in_ready,
        .in_data, .in_last, .out_valid, .out_ready, .out_sym, .out_last
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int width_of(input int code);
        return (code == 0) ? 8 : (code == 1) ? 12 : 16;
    endfunction

    function automatic logic [15:0] model_sym(input int si, input int w, input int total);
        logic [15:0] s = '0;
        for (int b = 0; b < w; b++) begin
            int idx = si * w + b;
            if (idx < total) s[b] = elems[idx / EW][idx % EW];
        end
        return s;
    endfunction

    task automatic run_stream(input int n, input int code, input int rdy_pct, input int vld_pct, input string tag);
        int w = width_of(code);
        int total = n * EW;
        int nsym = (total + w - 1) / w;
        int ei = 0;
        int si = 0;
        int guard = 0;
        logic held = 1'b0;
        logic [15:0] hsym = '0;
        logic hlast = 1'b0;
        bit rdy, vld;
        cfg_size = 3'(code);
        while (si < nsym && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (held)
                chk(out_valid && out_sym == hsym && out_last == hlast,
                    $sformatf("R7 hold %s", tag), {out_valid, out_last, out_sym}, {1'b1, hlast, hsym});
            if (in_ready)
                chk(!out_valid, $sformatf("R8 stall %s", tag), out_valid, 0);
            rdy = ($urandom % 100) < rdy_pct;
            out_ready = rdy;
            held = out_valid && !rdy;
            hsym = out_sym;
            hlast = out_last;
            if (out_valid && rdy) begin
                got[si] = out_sym;
                chk(out_sym == model_sym(si, w, total),
                    $sformatf("R3 R4 symbol %0d %s", si, tag), out_sym, model_sym(si, w, total));
                chk(out_last == (si == nsym - 1),
                    $sformatf("R6 last flag %0d %s", si, tag), out_last, (si == nsym - 1));
                si++;
            end
            if (ei < n) begin
                vld = ($urandom % 100) < vld_pct;
                in_valid = vld;
                in_data = elems[ei];
                in_last = (ei == n - 1);
                if (vld && in_ready) ei++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b0;
        chk(si == nsym, $sformatf("R6 symbol count %s", tag), si, nsym);
        chk(!out_valid && in_ready, $sformatf("R9 drained %s", tag), {out_valid, in_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid && !cfg_err, "R1 reset state",
            {in_ready, out_valid, cfg_err}, 3'b100);

        // R3: 8-bit symbols, LSB first
        elems[0] = 128'h0f0e0d0c0b0a09080706050403020100;
        run_stream(1, 0, 100, 100, "b8");
        chk(got[0] == 16'h0000 && got[5] == 16'h0005, "R3 order", {got[0], got[5]}, 32'h00000005);
        chk(got[15] == {8'h00, elems[0][127:120]}, "R2 8-bit top", got[15], elems[0][127:120]);

        // R2: 16-bit symbols
        elems[0] = {$urandom, $urandom, $urandom, $urandom};
        run_stream(1, 2, 60, 100, "b16");
        chk(got[7] == elems[0][127:112], "R2 16-bit top", got[7], elems[0][127:112]);

        // R4: 12-bit residue cycle over three elements
        for (int i = 0; i < 3; i++) elems[i] = {$urandom, $urandom, $urandom, $urandom};
        run_stream(3, 1, 70, 80, "b12x3");
        chk(got[10] == {4'h0, elems[1][3:0], elems[0][127:120]}, "R4 carry 8",
            got[10], {elems[1][3:0], elems[0][127:120]});
        chk(got[21] == {4'h0, elems[2][7:0], elems[1][127:124]}, "R4 carry 4",
            got[21], {elems[2][7:0], elems[1][127:124]});
        chk(got[31] == {4'h0, elems[2][127:116]}, "R4 exact end", got[31], elems[2][127:116]);

        // R6: padded residue at end of stream
        run_stream(1, 1, 50, 100, "b12x1");
        chk(got[10] == {8'h00, elems[0][127:120]}, "R6 pad 8", got[10], elems[0][127:120]);
        run_stream(2, 1, 50, 100, "b12x2");
        chk(got[21] == {12'h000, elems[1][127:124]}, "R6 pad 4", got[21], elems[1][127:124]);

        // R9: fresh start after a stream with a residue
        run_stream(1, 1, 100, 100, "b12 again");
        chk(got[0] == {4'h0, elems[0][11:0]}, "R9 no carry", got[0], elems[0][11:0]);

        // R5: reserved size codes
        for (int c = 3; c < 8; c++) begin
            cfg_size = 3'(c);
            in_valid = 1'b1;
            in_data = elems[0];
            out_ready = 1'b1;
            @(negedge clk);
            chk(cfg_err && !in_ready && !out_valid, $sformatf("R5 code %0d", c),
                {cfg_err, in_ready, out_valid}, 3'b100);
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        cfg_size = 3'd0;
        @(negedge clk);
        chk(!cfg_err && in_ready && !out_valid, "R5 recover", {cfg_err, in_ready, out_valid}, 3'b010);
        run_stream(1, 0, 100, 100, "R5 after");

        // random mix
        for (int k = 0; k < 10; k++) begin
            int n = 1 + ($urandom % 8);
            int code = $urandom % 3;
            for (int i = 0; i < n; i++) elems[i] = {$urandom, $urandom, $urandom, $urandom};
            run_stream(n, code, 30 + ($urandom % 71), 40 + ($urandom % 61), $sformatf("rand%0d", k));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule